// File: doc/BRIEF.md
# Triggered PWM Pulse Timer

This block is a 16-bit pulse generator that does nothing after being enabled until a start event arrives. The start event is either a chosen transition on an external trigger pin, which passes through a two-flop synchronizer and an edge detector, or a software strobe bit set in a control-register write. After the start event, a counter advances once per system clock. The system clock is the only count source. The counter wraps at a programmed period value. A set/reset output stage turns the two compare matches into a PWM waveform.

Software writes the period and duty compare values into buffer registers. These values become active only on the start event or at a period boundary, so a value written while the counter runs never cuts a period short. A second output toggles at each period boundary and gives a 50% square wave. It is live only while the software trigger source is selected, because in a real pin plan it shares a pad with the trigger input. The two compare events also come out as one-cycle interrupt pulses.

Top module: `trig_pwm_timer`

## Requirements
- R1: After the enable bit (CTRL bit 0, register address 0) is written to 1, the counter stays idle and the outputs stay low until a trigger is accepted. With external source (CTRL bit 3 = 0), a selected edge on `ext_trig_i` is accepted 3 clock edges after the pin changes.
- R2: Writing CTRL with bit 4 set is a software trigger. It starts counting only if the same write sets bit 0. It is ignored when the write clears bit 0.
- R3: The counter clears when it equals the active period value (buffer at address 1), so the period is period+1 clocks. `irq_cc0_o` pulses for one cycle exactly period+1 clocks after the triggering edge, and once every period+1 clocks after that.
- R4: Writes to addresses 1 and 2 go into buffers. A buffer moves into the active compare value only on an accepted trigger or at a period match. A period value written mid-run takes effect from the following period.
- R5: `pwm_o` goes high after a duty match (address 2 value) and low after a period match. When both match in the same cycle, the reset wins. The high time per period is period−duty clocks if duty < period, and zero otherwise.
- R6: `irq_cc1_o` pulses for one cycle on each duty match. There are two pulses per two periods when duty ≤ period, and none when duty > period.
- R7: With software source (CTRL bit 3 = 1), `sq_o` toggles on each period match, so it is high period+1 clocks out of every 2·(period+1). With external source, `sq_o` is held low.
- R8: CTRL bits 2:1 select the edge: 00 none, 01 rising, 10 falling, 11 both. A transition that is not selected starts nothing. External edges are ignored when the software source is selected.
- R9: A trigger accepted while running restarts the count from zero and suppresses any period match in that same cycle, so no `irq_cc0_o` pulse follows from that cycle.
- R10: Writing CTRL with bit 0 clear stops and clears the counter. From the next cycle on, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period buffer, 2 duty buffer |
| wr_data | input | 16 | Write data |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| pwm_o | output | 1 | PWM waveform from the set/reset stage |
| sq_o | output | 1 | 50% square wave, software source only |
| irq_cc0_o | output | 1 | Period match pulse |
| irq_cc1_o | output | 1 | Duty match pulse |

## Verification
Two collisions can land in one cycle. A restart trigger can meet a period match, and a duty match can meet a period match. The first is provoked by timing a software strobe so that it is sampled on the exact edge at which the count equals the period value. The bench then expects no period pulse in that cycle and a fresh full period afterwards. The second comes from the sweep over duty values equal to the period value, where the output must stay low while the duty interrupt still pulses.

// File: rtl/tpt_pkg.sv
// Shared constants and types for the triggered PWM pulse timer.
// Assumes a two-bit register address and a control word of at least five bits.
package tpt_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int          REG_AW         = 2;
    localparam logic [1:0]  ADDR_CTRL      = 2'd0;
    localparam logic [1:0]  ADDR_PERIOD    = 2'd1;
    localparam logic [1:0]  ADDR_DUTY      = 2'd2;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_EDGE_LSB   = 1;
    localparam int CTRL_SRC_BIT    = 3;
    localparam int CTRL_STROBE_BIT = 4;

endpackage

// File: rtl/tpt_regs.sv
// Register file: control bits plus period and duty buffer registers.
// Exposes both the stored control values and their next-cycle values, so that
// a control write acts on the same edge it is captured.
module tpt_regs
    import tpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              en_q,
    output logic              en_d,
    output logic              src_sw_q,
    output logic              src_sw_d,
    output edge_sel_e         edge_sel_q,
    output logic              sw_strobe,
    output logic [CNT_W-1:0]  period_buf,
    output logic [CNT_W-1:0]  duty_buf
);

    logic ctrl_wr;

    // Decode a control write and its next-state values.
    always_comb begin
        ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
        en_d      = ctrl_wr ? wr_data[CTRL_EN_BIT]  : en_q;
        src_sw_d  = ctrl_wr ? wr_data[CTRL_SRC_BIT] : src_sw_q;
        sw_strobe = ctrl_wr && wr_data[CTRL_STROBE_BIT];
    end

    // Hold the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            src_sw_q   <= 1'b0;
            edge_sel_q <= EDGE_NONE;
        end else begin
            en_q     <= en_d;
            src_sw_q <= src_sw_d;
            if (ctrl_wr)
                edge_sel_q <= edge_sel_e'(wr_data[CTRL_EDGE_LSB +: 2]);
        end
    end

    // Hold the compare buffers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_buf <= '0;
            duty_buf   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_PERIOD) period_buf <= wr_data;
            if (wr_addr == ADDR_DUTY)   duty_buf   <= wr_data;
        end
    end

    // R2: a strobe can only come from a control write
    a_r2_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_strobe |-> (wr_en && wr_addr == ADDR_CTRL));

endmodule

// File: rtl/tpt_edge_det.sv
// Synchronizes the asynchronous trigger pin and flags the selected transitions.
// Assumes SYNC_STAGES >= 2. Reports one pulse per accepted edge.
module tpt_edge_det
    import tpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  edge_sel_e sel,
    output logic      edge_pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rose, fell;

    // Shift the pin through the synchronizer chain and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], pin_i};
            prev_q <= sync_q[LAST];
        end
    end

    // Pick the transition kinds allowed by the select field.
    always_comb begin
        rose = sync_q[LAST] && !prev_q;
        fell = !sync_q[LAST] && prev_q;
        unique case (sel)
            EDGE_RISE: edge_pulse = rose;
            EDGE_FALL: edge_pulse = fell;
            EDGE_BOTH: edge_pulse = rose || fell;
            default:   edge_pulse = 1'b0;
        endcase
    end

    // R8: no edge is reported when edge detection is off
    a_r8_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |-> !edge_pulse);

endmodule

// File: rtl/tpt_counter.sv
// Gated up-counter with active compare registers loaded from the buffers.
// Idles at zero until a trigger, clears on a period match, and restarts on a
// trigger accepted while running. Counts once per clock.
module tpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic             trig,
    input  logic [CNT_W-1:0] period_buf,
    input  logic [CNT_W-1:0] duty_buf,
    output logic             running,
    output logic             match_per,
    output logic             match_duty
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_act_q;
    logic [CNT_W-1:0] duty_act_q;
    logic             live;

    // Compare the count against the active values; a trigger overrides.
    always_comb begin
        live       = running && en_d && !trig;
        match_per  = live && (cnt_q == per_act_q);
        match_duty = live && (cnt_q == duty_act_q);
    end

    // Run, clear and reload the counter and the active compare values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            cnt_q      <= '0;
            per_act_q  <= '0;
            duty_act_q <= '0;
        end else if (!en_d) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (trig) begin
            running    <= 1'b1;
            cnt_q      <= '0;
            per_act_q  <= period_buf;
            duty_act_q <= duty_buf;
        end else if (running) begin
            if (match_per) begin
                cnt_q      <= '0;
                per_act_q  <= period_buf;
                duty_act_q <= duty_buf;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the count never passes the active period value
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q <= per_act_q));
    // R10: an idle counter sits at zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt_q == '0));
    // R9: a trigger restarts from zero
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (running && cnt_q == '0));
    // R4: a trigger loads the buffered period
    a_r4_load_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (per_act_q == $past(period_buf)));

endmodule

// File: rtl/tpt_out.sv
// Output stage: set/reset PWM flip-flop, period toggle and interrupt pulses.
// A period match resets and a duty match sets; reset wins on a tie. Everything
// clears when the block is disabled or a trigger restarts the count.
module tpt_out (
    input  logic clk,
    input  logic rst_n,
    input  logic en_d,
    input  logic en_q,
    input  logic trig,
    input  logic running,
    input  logic src_sw_d,
    input  logic src_sw_q,
    input  logic match_per,
    input  logic match_duty,
    output logic pwm_q,
    output logic sq_q,
    output logic irq0_q,
    output logic irq1_q
);

    // Update the RS flip-flop, the toggle output and the interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q  <= 1'b0;
            sq_q   <= 1'b0;
            irq0_q <= 1'b0;
            irq1_q <= 1'b0;
        end else if (!en_d || trig) begin
            pwm_q  <= 1'b0;
            sq_q   <= 1'b0;
            irq0_q <= 1'b0;
            irq1_q <= 1'b0;
        end else begin
            irq0_q <= match_per;
            irq1_q <= match_duty;
            if (match_per)
                pwm_q <= 1'b0;
            else if (match_duty)
                pwm_q <= 1'b1;
            if (!src_sw_d)
                sq_q <= 1'b0;
            else if (match_per)
                sq_q <= !sq_q;
        end
    end

    // R5: the PWM output only rises together with a duty-match pulse
    a_r5_rise_with_duty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_q) |-> irq1_q);
    // R7: the square wave stays low with the external source
    a_r7_sq_low_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !src_sw_q |-> !sq_q);
    // R10: a disabled block drives nothing
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!pwm_q && !sq_q && !irq0_q && !irq1_q));
    // R6: an interrupt pulse needs a running counter one cycle earlier
    a_r6_irq_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0_q || irq1_q) |-> $past(running));

endmodule

// File: rtl/trig_pwm_timer.sv
// Top level of the triggered PWM pulse timer. Joins the register file, the
// trigger edge detector, the gated counter and the output stage. The system
// clock is the count clock. External edges count only with the external source.
module trig_pwm_timer
    import tpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_trig_i,
    output logic              pwm_o,
    output logic              sq_o,
    output logic              irq_cc0_o,
    output logic              irq_cc1_o
);

    logic             en_q, en_d, src_sw_q, src_sw_d, sw_strobe;
    edge_sel_e        edge_sel_q;
    logic [CNT_W-1:0] period_buf, duty_buf;
    logic             ext_edge, trig, running, match_per, match_duty;

    tpt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_q(en_q), .en_d(en_d), .src_sw_q(src_sw_q),
        .src_sw_d(src_sw_d), .edge_sel_q(edge_sel_q), .sw_strobe(sw_strobe),
        .period_buf(period_buf), .duty_buf(duty_buf)
    );

    tpt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_trig_i), .sel(edge_sel_q),
        .edge_pulse(ext_edge)
    );

    // Accept a trigger from the strobe, or from the pin with external source.
    always_comb begin
        trig = en_d && (sw_strobe || (ext_edge && !src_sw_d));
    end

    tpt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .trig(trig),
        .period_buf(period_buf), .duty_buf(duty_buf), .running(running),
        .match_per(match_per), .match_duty(match_duty)
    );

    tpt_out out_i (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .en_q(en_q), .trig(trig),
        .running(running), .src_sw_d(src_sw_d), .src_sw_q(src_sw_q),
        .match_per(match_per), .match_duty(match_duty), .pwm_q(pwm_o),
        .sq_q(sq_o), .irq0_q(irq_cc0_o), .irq1_q(irq_cc1_o)
    );

    // R1: nothing runs while disabled
    a_r1_idle_until_en: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !running);

endmodule

// File: tb/trig_pwm_timer_tb.sv
// Self-checking bench: sweeps period and duty values under software trigger,
// then exercises external edges, buffering, restart collisions and disable.
module trig_pwm_timer_tb_top;
    import tpt_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ext_trig_i = 1'b0;
    logic        pwm_o, sq_o, irq_cc0_o, irq_cc1_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    trig_pwm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_trig_i(ext_trig_i), .pwm_o(pwm_o),
        .sq_o(sq_o), .irq_cc0_o(irq_cc0_o), .irq_cc1_o(irq_cc1_o)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One register write; called at a falling edge, returns at the next one.
    task automatic wr(logic [1:0] a, int d);
        wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic quiet(int n, string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hits += int'(irq_cc0_o) + int'(irq_cc1_o) + int'(pwm_o) + int'(sq_o);
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic first_irq(int maxn, output int idx);
        idx = -1;
        for (int i = 0; i < maxn; i++) begin
            if (irq_cc0_o) begin idx = i; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int idx, g, sum, P, first, ph, sh, i0, i1, exp_ph;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pwm_o, sq_o, irq_cc0_o, irq_cc1_o} == 4'b0, "R10 reset state",
            int'({pwm_o, sq_o, irq_cc0_o, irq_cc1_o}), 0);

        // R3 R5 R6 R7 R4: sweep period 0..7 and duty 0..9 with software trigger
        for (int c0 = 0; c0 < 8; c0++) begin
            for (int c1 = 0; c1 < 10; c1++) begin
                wr(ADDR_CTRL, 0); wr(ADDR_PERIOD, c0); wr(ADDR_DUTY, c1);
                wr(ADDR_CTRL, 25);
                P = c0 + 1; first = -1; ph = 0; sh = 0; i0 = 0; i1 = 0;
                for (int k = 0; k <= 2 * P; k++) begin
                    if (irq_cc0_o && first < 0) first = k;
                    if (k >= 1) begin
                        ph += int'(pwm_o); sh += int'(sq_o);
                        i0 += int'(irq_cc0_o); i1 += int'(irq_cc1_o);
                    end
                    @(negedge clk);
                end
                exp_ph = (c1 < c0) ? 2 * (c0 - c1) : 0;
                chk(first == P, "R3 first period pulse", first, P);
                chk(i0 == 2, "R3 period pulses", i0, 2);
                chk(ph == exp_ph, "R5 pwm high time", ph, exp_ph);
                chk(i1 == ((c1 <= c0) ? 2 : 0), "R6 duty pulses", i1, (c1 <= c0) ? 2 : 0);
                chk(sh == P, "R7 square high time", sh, P);
            end
        end

        // R1: enabled with external rising edge, idle until the pin rises
        wr(ADDR_CTRL, 0); wr(ADDR_PERIOD, 3); wr(ADDR_DUTY, 1);
        wr(ADDR_CTRL, 3);
        quiet(10, "R1 idle before trigger");
        ext_trig_i = 1'b1; @(negedge clk);
        first_irq(30, idx);
        chk(idx == 6, "R1 external rising start", idx, 6);
        sum = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); sum += int'(sq_o); end
        chk(sum == 0, "R7 square low with external source", sum, 0);

        // R8: falling edge ignored under rising select, accepted under falling
        wr(ADDR_CTRL, 0); wr(ADDR_CTRL, 3);
        ext_trig_i = 1'b0;
        quiet(12, "R8 falling ignored when rising selected");
        wr(ADDR_CTRL, 5);
        ext_trig_i = 1'b1;
        quiet(12, "R8 rising ignored when falling selected");
        ext_trig_i = 1'b0; @(negedge clk);
        first_irq(30, idx);
        chk(idx == 6, "R8 falling select start", idx, 6);
        wr(ADDR_CTRL, 0); wr(ADDR_CTRL, 7);
        ext_trig_i = 1'b1; @(negedge clk);
        first_irq(30, idx);
        chk(idx == 6, "R8 both-edge select start", idx, 6);
        wr(ADDR_CTRL, 0); wr(ADDR_CTRL, 1);
        ext_trig_i = 1'b0;
        quiet(12, "R8 none select ignores fall");
        ext_trig_i = 1'b1;
        quiet(12, "R8 none select ignores rise");
        wr(ADDR_CTRL, 0); wr(ADDR_CTRL, 15);
        ext_trig_i = 1'b0;
        quiet(12, "R8 pin ignored with software source");

        // R2: strobe with enable cleared starts nothing
        wr(ADDR_CTRL, 0); wr(ADDR_CTRL, 24);
        quiet(12, "R2 strobe without enable");

        // R4: period written mid-run takes effect one period later
        wr(ADDR_CTRL, 0); wr(ADDR_PERIOD, 3); wr(ADDR_DUTY, 1);
        wr(ADDR_CTRL, 25);
        first_irq(30, idx);
        wr(ADDR_PERIOD, 5);
        g = 1;
        while (!irq_cc0_o && g < 40) begin @(negedge clk); g++; end
        chk(g == 4, "R4 running period kept", g, 4);
        @(negedge clk); g = 1;
        while (!irq_cc0_o && g < 40) begin @(negedge clk); g++; end
        chk(g == 6, "R4 new period after match", g, 6);

        // R9: restart strobe lands on the period-match cycle
        wr(ADDR_CTRL, 0); wr(ADDR_PERIOD, 4); wr(ADDR_DUTY, 1);
        wr(ADDR_CTRL, 25);
        repeat (4) @(negedge clk);
        wr(ADDR_CTRL, 25);
        chk(!irq_cc0_o, "R9 match suppressed by restart", int'(irq_cc0_o), 0);
        first_irq(30, idx);
        chk(idx == 5, "R9 full period after restart", idx, 5);

        // R10: disable while the PWM output is high
        g = 0;
        while (!pwm_o && g < 20) begin @(negedge clk); g++; end
        chk(pwm_o, "R10 pwm high before disable", int'(pwm_o), 1);
        wr(ADDR_CTRL, 0);
        chk(!pwm_o && !sq_o, "R10 outputs low after disable",
            int'({pwm_o, sq_o}), 0);
        quiet(12, "R10 stays stopped");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule